// File: doc/BRIEF.md
# Protected Nonvolatile Byte-Store Controller

This block is the register front end that a small CPU uses to reach an on-chip nonvolatile byte store. Four registers sit on a simple single-cycle bus: a data register, an address register, a control/status register and a write-only unlock port. The store is modelled as a byte array whose write takes a programmable number of clock cycles. Software reads a byte by setting a read bit, which copies the addressed byte into the data register. It writes a byte by placing data and address, enabling writes, unlocking, and then setting a start bit.

Writes are guarded three ways. A power-up lockout timer must run out after power-on reset. The enable bit must already be set. A two-key unlock sequence must come immediately before the start request. A warm (non-power-on) reset that arrives while a write is running cancels the write and sets an error flag. That flag, the data register and the address register all survive the warm reset. Completion raises an interrupt flag, which also drives an output pin.

Top module: `nvm_ctl`

## Requirements
- R1: Bus address 0x08 selects the data register and 0x09 selects the address register. Both read back what was last written to them. The address register keeps AW bits (default 6) and reads zero above them. Any other unlisted address reads 0x00.
- R2: The control register at 0x88 reads {3'b000, done_flag, err_flag, wr_en, wr_busy, rd_go} from bit 7 down to bit 0. The unlock port at 0x89 always reads 0x00.
- R3: After power-on reset the control, data and address registers all read 0x00.
- R4: A warm reset sets err_flag to 1 if a write was in progress and to 0 if not. It clears done_flag, wr_en, wr_busy and rd_go, and leaves the data and address registers unchanged. A write it cuts off does not change the stored byte.
- R5: For PWRUP_CYC clock edges after power-on reset is released, a write start request is ignored.
- R6: A write starts only if wr_en was already 1 and the two bus writes just before the start request were 0x55 and then 0xAA to 0x89. Any other bus write between the unlock and the start request cancels the unlock. A request that fails these conditions leaves wr_busy at 0.
- R7: wr_busy reads 1 from the edge that accepts the start until WR_CYC edges later. At that edge wr_busy clears, done_flag sets and the byte is stored. Writing 0 to wr_busy does not clear it.
- R8: Writing 1 to rd_go loads the byte at the current address into the data register on the following clock edge.
- R9: rd_go reads 1 for exactly one cycle. A read request made while wr_busy is 1 is ignored.
- R10: Writing 0 to done_flag clears it and writing 1 to it has no effect. The irq output follows done_flag.
- R11: Writing 0 to err_flag clears it and writing 1 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low; restarts the lockout timer |
| warm_rst_n | input | 1 | Synchronous warm reset, active low |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| irq | output | 1 | Write-complete interrupt (done_flag) |

## Verification
Register writes and flag changes show on bus_rdata in the cycle after the edge that samples the bus write. wr_busy shows in the cycle after the start request, and done_flag with irq shows WR_CYC edges after that. A read lands in the data register one edge after rd_go is seen as 1. The bench drives the bus at the falling edge and updates a behavioural model at each rising edge, then compares bus_rdata and irq half a nanosecond later. Directed checks count edges up to the irq rise and sample the read result on the second edge after the request.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   localparam logic [7:0] A_DATA   = 8'h08;
   localparam logic [7:0] A_ADDR   = 8'h09;
   localparam logic [7:0] A_CTL    = 8'h88;
   localparam logic [7:0] A_UNLOCK = 8'h89;

   localparam int B_RD   = 0;
   localparam int B_BUSY = 1;
   localparam int B_WEN  = 2;
   localparam int B_ERR  = 3;
   localparam int B_DONE = 4;

   localparam logic [7:0] KEY_FIRST  = 8'h55;
   localparam logic [7:0] KEY_SECOND = 8'hAA;

   typedef enum logic [1:0] {
      LK_IDLE  = 2'd0,
      LK_HALF  = 2'd1,
      LK_ARMED = 2'd2
   } lock_e;
endpackage

// File: rtl/nvm_pwrup_timer.sv
module nvm_pwrup_timer #(
   parameter int unsigned CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic ready
);
   generate
      if (CYC == 0) begin : g_none
         logic unused_in;
         assign unused_in = clk ^ rst_n;
         assign ready = 1'b1;
      end else begin : g_cnt
         localparam int CW = $clog2(CYC + 1);
         localparam logic [CW-1:0] LIMIT = CW'(CYC);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
         end
         assign ready = (cnt_q == LIMIT);
      end
   endgenerate
endmodule

// File: rtl/nvm_unlock.sv
module nvm_unlock
   import nvm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       warm_rst_n,
   input  logic       wr,
   input  logic [7:0] addr,
   input  logic [7:0] wdata,
   output logic       armed
);
   lock_e st_q;
   logic  to_port;
   assign to_port = (addr == A_UNLOCK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                st_q <= LK_IDLE;
      else if (!warm_rst_n)                      st_q <= LK_IDLE;
      else if (wr) begin
         if (to_port && wdata == KEY_FIRST)      st_q <= LK_HALF;
         else if (st_q == LK_HALF && to_port && wdata == KEY_SECOND)
                                                 st_q <= LK_ARMED;
         else                                    st_q <= LK_IDLE;
      end
   end

   assign armed = (st_q == LK_ARMED);
endmodule

// File: rtl/nvm_wr_engine.sv
module nvm_wr_engine #(
   parameter int AW     = 6,
   parameter int WR_CYC = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          abort,
   input  logic          start,
   input  logic [AW-1:0] st_addr,
   input  logic [7:0]    st_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output logic          busy,
   output logic          done
);
   localparam int DEPTH = 1 << AW;
   localparam int CW    = $clog2(WR_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(WR_CYC - 1);

   logic [7:0]    mem [DEPTH];
   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic [AW-1:0] a_q;
   logic [7:0]    d_q;

   assign done = busy_q && (cnt_q == '0);
   assign busy = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         a_q    <= '0;
         d_q    <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= LOAD;
         a_q    <= st_addr;
         d_q    <= st_data;
      end else if (done) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (done && !abort) mem[a_q] <= d_q;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nvm_ctl.sv
module nvm_ctl
   import nvm_pkg::*;
#(
   parameter int          AW        = 6,
   parameter int          WR_CYC    = 16,
   parameter int unsigned PWRUP_CYC = 18_000_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       warm_rst_n,
   input  logic       bus_wr,
   input  logic [7:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       irq
);
   generate
      if (AW < 1 || AW > 8) begin : g_bad_aw
         $error("nvm_ctl: AW must be 1..8");
      end
      if (WR_CYC < 1) begin : g_bad_wr
         $error("nvm_ctl: WR_CYC must be at least 1");
      end
   endgenerate

   logic [7:0]    data_q;
   logic [AW-1:0] addr_q;
   logic          wen_q, rs_q, irq_q, err_q;
   logic          busy, done, armed, pu_ready;
   logic [7:0]    mem_rd;
   logic [7:0]    ctl_view;

   logic ctl_wr, start, rd_req;
   assign ctl_wr = bus_wr && (bus_addr == A_CTL);
   assign start  = ctl_wr && bus_wdata[B_BUSY] && wen_q && armed && pu_ready && !busy;
   assign rd_req = ctl_wr && bus_wdata[B_RD] && !busy;

   nvm_pwrup_timer #(.CYC(PWRUP_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .ready(pu_ready)
   );

   nvm_unlock u_unlock (
      .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n),
      .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .armed(armed)
   );

   nvm_wr_engine #(.AW(AW), .WR_CYC(WR_CYC)) u_engine (
      .clk(clk), .rst_n(rst_n), .abort(!warm_rst_n), .start(start),
      .st_addr(addr_q), .st_data(data_q), .rd_addr(addr_q),
      .rd_data(mem_rd), .busy(busy), .done(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         addr_q <= '0;
         wen_q  <= 1'b0;
         rs_q   <= 1'b0;
         irq_q  <= 1'b0;
         err_q  <= 1'b0;
      end else if (!warm_rst_n) begin
         err_q  <= busy;
         wen_q  <= 1'b0;
         rs_q   <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (rs_q)                                 data_q <= mem_rd;
         else if (bus_wr && bus_addr == A_DATA)    data_q <= bus_wdata;
         if (bus_wr && bus_addr == A_ADDR)         addr_q <= bus_wdata[AW-1:0];
         rs_q <= rd_req;
         if (ctl_wr)                               wen_q  <= bus_wdata[B_WEN];
         if (done)                                 irq_q  <= 1'b1;
         else if (ctl_wr && !bus_wdata[B_DONE])    irq_q  <= 1'b0;
         if (ctl_wr && !bus_wdata[B_ERR])          err_q  <= 1'b0;
      end
   end

   always_comb begin
      ctl_view         = '0;
      ctl_view[B_RD]   = rs_q;
      ctl_view[B_BUSY] = busy;
      ctl_view[B_WEN]  = wen_q;
      ctl_view[B_ERR]  = err_q;
      ctl_view[B_DONE] = irq_q;
   end

   always_comb begin
      case (bus_addr)
         A_DATA:  bus_rdata = data_q;
         A_ADDR:  bus_rdata = 8'(addr_q);
         A_CTL:   bus_rdata = ctl_view;
         default: bus_rdata = 8'h00;
      endcase
   end

   assign irq = irq_q;
endmodule

// File: rtl/nvm_ctl_chk.sv
module nvm_ctl_chk
   import nvm_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       warm_rst_n,
   input logic       bus_wr,
   input logic [7:0] bus_addr,
   input logic       wd_rd,
   input logic       wd_err,
   input logic [7:0] bus_rdata,
   input logic       irq,
   input logic       ws,
   input logic       rs,
   input logic       err,
   input logic       wen,
   input logic       armed,
   input logic       ready
);
   assert_done_sets_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ws) && $past(warm_rst_n) |-> irq);

   assert_lockout_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ws) |-> $past(ready));

   assert_start_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ws) |-> $past(armed) && $past(wen));

   assert_rd_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rs && !(bus_wr && bus_addr == A_CTL && wd_rd) |=> !rs);

   assert_no_rd_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ws && bus_wr && bus_addr == A_CTL |=> !rs);

   assert_unlock_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == A_UNLOCK |-> bus_rdata == 8'h00);

   assert_ctl_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == A_CTL |-> bus_rdata[7:5] == 3'b000);

   assert_err_not_settable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_CTL && wd_err && warm_rst_n && !err |=> !err);

   assert_warm_err_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !warm_rst_n |=> err == $past(ws));
endmodule

bind nvm_ctl nvm_ctl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n),
   .bus_wr(bus_wr), .bus_addr(bus_addr),
   .wd_rd(bus_wdata[0]), .wd_err(bus_wdata[3]),
   .bus_rdata(bus_rdata), .irq(irq),
   .ws(busy), .rs(rs_q), .err(err_q), .wen(wen_q),
   .armed(armed), .ready(pu_ready)
);

// File: tb/nvm_ctl_tb.sv
`timescale 1ns/1ps
module nvm_ctl_tb;
   localparam int AW = 6;
   localparam int D  = 1 << AW;
   localparam int W  = 6;
   localparam int P  = 40;

   logic       clk = 1'b0;
   logic       rst_n, warm_rst_n, bus_wr, irq;
   logic [7:0] bus_addr, bus_wdata, bus_rdata;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   nvm_ctl #(.AW(AW), .WR_CYC(W), .PWRUP_CYC(P)) u_dut (
      .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   // behavioural reference model
   logic [7:0] m_mem [int];
   logic [7:0] m_data, m_wd, t_od;
   int  m_addr, m_cnt, m_wa, m_tmr, m_lock, t_oa;
   bit  m_irq, m_err, m_wen, m_rs, m_busy;
   bit  t_rdy, t_cw, t_fin, t_go;

   function automatic logic [7:0] mrd(int a);
      if (m_mem.exists(a)) return m_mem[a];
      return 8'h00;
   endfunction

   function automatic logic [7:0] exp_rd(logic [7:0] a);
      case (a)
         8'h08:   return m_data;
         8'h09:   return 8'(m_addr);
         8'h88:   return {3'b000, m_irq, m_err, m_wen, m_busy, m_rs};
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always begin
      @(posedge clk);
      if (!rst_n) begin
         m_data = 0; m_addr = 0; m_irq = 0; m_err = 0; m_wen = 0; m_rs = 0;
         m_busy = 0; m_cnt = 0; m_lock = 0; m_tmr = 0;
      end else begin
         t_rdy = (m_tmr >= P);
         if (m_tmr < P) m_tmr++;
         if (!warm_rst_n) begin
            m_err = m_busy; m_wen = 0; m_rs = 0; m_irq = 0; m_busy = 0; m_lock = 0;
         end else begin
            t_cw  = bus_wr && bus_addr == 8'h88;
            t_fin = m_busy && m_cnt == 0;
            t_go  = t_cw && bus_wdata[1] && m_wen && m_lock == 2 && t_rdy && !m_busy;
            t_od  = m_data;
            t_oa  = m_addr;
            if (m_rs) m_data = mrd(t_oa);
            else if (bus_wr && bus_addr == 8'h08) m_data = bus_wdata;
            if (bus_wr && bus_addr == 8'h09) m_addr = bus_wdata % D;
            m_rs = t_cw && bus_wdata[0] && !m_busy;
            if (t_cw) m_wen = bus_wdata[2];
            if (t_fin) m_irq = 1;
            else if (t_cw && !bus_wdata[4]) m_irq = 0;
            if (t_cw && !bus_wdata[3]) m_err = 0;
            if (t_fin) begin m_mem[m_wa] = m_wd; m_busy = 0; end
            else if (t_go) begin m_busy = 1; m_cnt = W - 1; m_wa = t_oa; m_wd = t_od; end
            else if (m_busy) m_cnt--;
            if (bus_wr) begin
               if (bus_addr == 8'h89 && bus_wdata == 8'h55) m_lock = 1;
               else if (m_lock == 1 && bus_addr == 8'h89 && bus_wdata == 8'hAA) m_lock = 2;
               else m_lock = 0;
            end
         end
      end
      #0.5;
      chk("R1 model rdata", bus_rdata, exp_rd(bus_addr));
      chk("R10 model irq", irq, m_irq);
   end

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic peek(logic [7:0] a, output logic [7:0] v);
      bus_addr = a;
      #0.2 v = bus_rdata;
   endtask

   task automatic unlock();
      wr(8'h89, 8'h55);
      wr(8'h89, 8'hAA);
   endtask

   task automatic wait_irq(output int n);
      n = 0;
      for (int i = 1; i <= 4 * W; i++) begin
         @(posedge clk);
         #1.2;
         if (irq && n == 0) n = i;
         if (n != 0) break;
      end
   endtask

   task automatic warm_pulse();
      @(negedge clk); warm_rst_n = 1'b0;
      @(negedge clk); warm_rst_n = 1'b1;
   endtask

   logic [7:0] v;
   int n;

   initial begin
      rst_n = 0; warm_rst_n = 1; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #0.3;
      peek(8'h88, v); chk("R3 ctl after POR", v, 8'h00);
      peek(8'h08, v); chk("R3 data after POR", v, 8'h00);
      peek(8'h09, v); chk("R3 addr after POR", v, 8'h00);
      peek(8'h89, v); chk("R2 unlock reads zero", v, 8'h00);

      wr(8'h08, 8'h3C); wr(8'h09, 8'h05);
      peek(8'h08, v); chk("R1 data readback", v, 8'h3C);
      peek(8'h09, v); chk("R1 addr readback", v, 8'h05);
      peek(8'h10, v); chk("R1 unlisted addr", v, 8'h00);
      wr(8'h09, 8'hC5);
      peek(8'h09, v); chk("R1 addr upper bits zero", v, 8'h05);

      // lockout window
      wr(8'h88, 8'h04); unlock(); wr(8'h88, 8'h06);
      peek(8'h88, v); chk("R5 start in lockout ignored", v, 8'h04);
      repeat (P + 5) @(posedge clk);

      // gating
      wr(8'h88, 8'h06);
      peek(8'h88, v); chk("R6 start without unlock", v, 8'h04);
      wr(8'h89, 8'h55); wr(8'h08, 8'h3C); wr(8'h89, 8'hAA); wr(8'h88, 8'h06);
      peek(8'h88, v); chk("R6 interrupted unlock", v, 8'h04);

      // proper write
      unlock(); wr(8'h88, 8'h06);
      peek(8'h88, v); chk("R7 busy after start", v, 8'h06);
      wait_irq(n); chk("R7 write latency", n, W);
      peek(8'h88, v); chk("R7 done flag, busy clear", v, 8'h14);
      chk("R10 irq pin", irq, 1);
      wr(8'h88, 8'h14);
      peek(8'h88, v); chk("R10 write 1 no effect", v, 8'h14);
      wr(8'h88, 8'h04);
      peek(8'h88, v); chk("R10 write 0 clears", v, 8'h04);
      wr(8'h88, 8'h0C);
      peek(8'h88, v); chk("R11 write 1 does not set", v, 8'h04);

      // read verify
      wr(8'h08, 8'h00); wr(8'h88, 8'h05);
      peek(8'h88, v); chk("R9 rd bit set", v, 8'h05);
      @(posedge clk); #1.2;
      peek(8'h88, v); chk("R9 rd bit self-clears", v, 8'h04);
      peek(8'h08, v); chk("R8 read loads byte", v, 8'h3C);

      // busy: read ignored, busy not clearable
      wr(8'h08, 8'h99); wr(8'h09, 8'h07); unlock(); wr(8'h88, 8'h06);
      wr(8'h88, 8'h07);
      peek(8'h88, v); chk("R9 read during write ignored", v, 8'h06);
      peek(8'h08, v); chk("R9 data untouched", v, 8'h99);
      wr(8'h88, 8'h04);
      peek(8'h88, v); chk("R7 software cannot clear busy", v, 8'h06);
      wait_irq(n);
      wr(8'h88, 8'h04); wr(8'h08, 8'h00); wr(8'h88, 8'h05);
      @(posedge clk); #1.2;
      peek(8'h08, v); chk("R7 byte stored", v, 8'h99);

      // abort by warm reset
      wr(8'h08, 8'h22); wr(8'h09, 8'h0A); unlock(); wr(8'h88, 8'h06);
      wait_irq(n); wr(8'h88, 8'h04);
      wr(8'h08, 8'h11); unlock(); wr(8'h88, 8'h06);
      repeat (2) @(posedge clk);
      warm_pulse();
      #0.3;
      peek(8'h88, v); chk("R4 warm reset mid-write", v, 8'h08);
      peek(8'h08, v); chk("R4 data kept", v, 8'h11);
      peek(8'h09, v); chk("R4 addr kept", v, 8'h0A);
      wr(8'h88, 8'h09);
      @(posedge clk); #1.2;
      peek(8'h88, v); chk("R11 err kept on write 1", v, 8'h08);
      peek(8'h08, v); chk("R4 aborted byte unchanged", v, 8'h22);
      wr(8'h88, 8'h00);
      peek(8'h88, v); chk("R11 err cleared", v, 8'h00);
      warm_pulse();
      #0.3;
      peek(8'h88, v); chk("R4 idle warm reset no error", v, 8'h00);

      repeat (2) @(posedge clk);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #800000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog R7: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule